// File: doc/BRIEF.md
# Quad Lookup-Table Trigger Unit

This block decides, sample by sample, when a 16-channel logic capture has met its programmed trigger condition. The channels are cut into four groups of four bits. Each group value picks one entry of a 16-entry one-bit truth table. There is one table per group for each of four match terms. A term is true when every one of its four tables says yes. Two selectable terms are merged by a programmable operator. A counter with a prescaler and two 16-bit compare values can gate the result. A separate edge path adds single-pin rising or falling conditions.

Configuration arrives as byte writes on a small address port. The tables are filled row by row: two bytes stage one bit of every table, and a commit write then stores that row. A six-byte parameter block picks the terms, the operator, the counter source and the gating mode. A fast mode drops the level logic and fires on one pin edge only. The first hit gives a one-cycle pulse and sets a sticky flag. Both stay quiet until a rearm.

Top module: `qlt_trigger`

## Requirements
- R1: After synchronous reset, trig_pulse and triggered are 0. Every table entry is 1, the parameter block is zero (term 0 alone, no gating), both edge masks are zero and fast mode is off, so the first valid sample triggers.
- R2: Addresses 0 and 1 stage the low and high byte of a 16-bit row word. A write to address 2 whose upper nibble is 0x3 stores row index = its low nibble: bit t*4+q of the word goes to that entry of the table for term t, group q. A write to address 2 with any other upper nibble changes nothing.
- R3: Group q is sample bits [4q+3:4q]. A term is true when the table entry selected by every group is 1.
- R4: Parameter bytes are written at addresses 3..8. Byte 3 holds gate mode [7:6] and prescale [5:0]. Byte 4 holds count source [7:6], operator [5:4], term A select [3:2] and term B select [1:0]. Bytes 5,6 hold compare B little-endian; bytes 7,8 hold compare A little-endian. Operator codes: 0 = A, 1 = A and B, 2 = A or B, 3 = A xor B; the result is M.
- R5: On each valid sample a 16-bit counter increments (saturating) when its source is true. Source codes: 0 = M, 1 = A, 2 = B, 3 = prescaler tick. The tick is true on every (prescale+1)-th valid sample, starting with the (prescale+1)-th after rearm. Rearm and reset clear the counter and the prescaler.
- R6: Gate mode codes use the counter value from before the current sample's increment: 0 = M; 1 = counter >= compare A; 2 = M and counter >= compare B; 3 = M and compare B <= counter <= compare A.
- R7: In normal mode the level result must also meet the edge condition. Edge masks are written at 9,10 (rising, low/high byte) and 11,12 (falling). No mask bit set adds no condition. Exactly one pin set requires that pin's edge against the previous valid sample. More than one pin set blocks triggering.
- R8: Fast mode (address 13 bit 0 = 1) ignores the level logic. It triggers only when exactly one pin is set across both masks and that pin shows its selected edge.
- R9: An edge needs a previous valid sample since reset; the first valid sample never produces an edge.
- R10: A trigger shows as trig_pulse high for the one cycle after the sample and sets triggered. No further pulse occurs while triggered. A rearm cycle clears triggered and produces no pulse.
- R11: A cycle with smp_valid low produces no pulse and does not change the previous sample, counter or prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration byte |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Channel sample |
| rearm | input | 1 | Clear the sticky flag, counter and prescaler |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky triggered flag |

## Verification
The assertions assume that rearm, sample valid and configuration writes are plain synchronous levels. They also assume the edge masks and mode bit change only through the write port, so a pulse can be traced to the register values of the cycle before it. The stimulus never places a configuration write or a rearm in a cycle that carries a valid sample. Each expected pulse therefore depends only on the sample of that cycle and on configuration that is already settled.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
    localparam int QW      = 4;
    localparam int NQUAD   = 4;
    localparam int NCH     = QW * NQUAD;
    localparam int NTERM   = 4;
    localparam int NENT    = 1 << QW;
    localparam int ROW_W   = NTERM * NQUAD;
    localparam int CW      = 16;
    localparam int PRE_W   = 6;
    localparam int TSEL_W  = $clog2(NTERM);

    localparam logic [3:0] A_ROW_LO   = 4'd0;
    localparam logic [3:0] A_ROW_HI   = 4'd1;
    localparam logic [3:0] A_COMMIT   = 4'd2;
    localparam logic [3:0] A_PRM0     = 4'd3;
    localparam logic [3:0] A_PRM1     = 4'd4;
    localparam logic [3:0] A_CMPB_LO  = 4'd5;
    localparam logic [3:0] A_CMPB_HI  = 4'd6;
    localparam logic [3:0] A_CMPA_LO  = 4'd7;
    localparam logic [3:0] A_CMPA_HI  = 4'd8;
    localparam logic [3:0] A_RISE_LO  = 4'd9;
    localparam logic [3:0] A_RISE_HI  = 4'd10;
    localparam logic [3:0] A_FALL_LO  = 4'd11;
    localparam logic [3:0] A_FALL_HI  = 4'd12;
    localparam logic [3:0] A_MODE     = 4'd13;
    localparam logic [3:0] COMMIT_KEY = 4'h3;

    typedef enum logic [1:0] {OP_A, OP_AND, OP_OR, OP_XOR} op_e;
    typedef enum logic [1:0] {GATE_NONE, GATE_COUNT, GATE_ABOVE, GATE_WINDOW} gate_e;
    typedef enum logic [1:0] {SRC_M, SRC_A, SRC_B, SRC_TICK} src_e;

    typedef struct packed {
        gate_e              gate;
        logic [PRE_W-1:0]   presc;
        src_e               src;
        op_e                op;
        logic [TSEL_W-1:0]  sel_a;
        logic [TSEL_W-1:0]  sel_b;
        logic [CW-1:0]      cmp_b;
        logic [CW-1:0]      cmp_a;
    } param_t;

    function automatic logic merge(op_e op, logic a, logic b);
        case (op)
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            default: return a;
        endcase
    endfunction
endpackage

// File: rtl/qlt_lut_bank.sv
module qlt_lut_bank
    import qlt_pkg::*;
#(
    parameter int N_TERM = NTERM,
    parameter int N_GRP  = NQUAD,
    parameter int GW     = QW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit,
    input  logic [GW-1:0]           row_idx,
    input  logic [N_TERM*N_GRP-1:0] row_bits,
    input  logic [N_GRP*GW-1:0]     sample,
    output logic [N_TERM-1:0]       term_hit
);
    localparam int N_ENT = 1 << GW;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_GRP-1:0] grp_hit;
        for (genvar q = 0; q < N_GRP; q++) begin : g_grp
            logic [N_ENT-1:0] tbl;
            always_ff @(posedge clk) begin
                if (rst)
                    tbl <= '1;
                else if (commit)
                    tbl[row_idx] <= row_bits[t*N_GRP+q];
            end
            assign grp_hit[q] = tbl[sample[q*GW +: GW]];
        end
        assign term_hit[t] = &grp_hit;
    end
endmodule

// File: rtl/qlt_edge.sv
module qlt_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] rise_mask,
    input  logic [W-1:0] fall_mask,
    output logic         sel_none,
    output logic         sel_one,
    output logic         edge_hit
);
    logic [W-1:0] prev;
    logic         prev_ok;
    logic [W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (valid) begin
            prev    <= sample;
            prev_ok <= 1'b1;
        end
    end

    assign sel      = rise_mask | fall_mask;
    assign sel_none = (sel == '0);
    assign sel_one  = !sel_none && ((sel & (sel - 1'b1)) == '0);
    assign edge_hit = prev_ok &&
                      (|((rise_mask & ~prev & sample) | (fall_mask & prev & ~sample)));
endmodule

// File: rtl/qlt_gate.sv
module qlt_gate
    import qlt_pkg::*;
#(
    parameter int N_TERM = NTERM,
    parameter int C_W    = CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rearm,
    input  logic              valid,
    input  param_t            prm,
    input  logic [N_TERM-1:0] term_hit,
    output logic              level_ok
);
    logic [PRE_W-1:0] pre;
    logic [C_W-1:0]   cnt;
    logic             a, b, m, tick, src_on;

    assign a    = term_hit[prm.sel_a];
    assign b    = term_hit[prm.sel_b];
    assign m    = merge(prm.op, a, b);
    assign tick = (pre == prm.presc);

    always_comb begin
        case (prm.src)
            SRC_A:    src_on = a;
            SRC_B:    src_on = b;
            SRC_TICK: src_on = tick;
            default:  src_on = m;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            pre <= '0;
            cnt <= '0;
        end else if (valid) begin
            pre <= tick ? '0 : pre + 1'b1;
            if (src_on && cnt != '1)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        case (prm.gate)
            GATE_COUNT:  level_ok = (cnt >= prm.cmp_a);
            GATE_ABOVE:  level_ok = m && (cnt >= prm.cmp_b);
            GATE_WINDOW: level_ok = m && (cnt >= prm.cmp_b) && (cnt <= prm.cmp_a);
            default:     level_ok = m;
        endcase
    end
endmodule

// File: rtl/qlt_trigger.sv
module qlt_trigger
    import qlt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [3:0]     cfg_addr,
    input  logic [7:0]     cfg_wdata,
    input  logic           smp_valid,
    input  logic [NCH-1:0] smp_data,
    input  logic           rearm,
    output logic           trig_pulse,
    output logic           triggered
);
    logic [ROW_W-1:0] row_stage;
    param_t           prm;
    logic [NCH-1:0]   rise_mask, fall_mask;
    logic             fast_mode;
    logic             commit;
    logic [NTERM-1:0] term_hit;
    logic             level_ok, sel_none, sel_one, edge_hit, cond;

    assign commit = cfg_we && (cfg_addr == A_COMMIT) && (cfg_wdata[7:4] == COMMIT_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_stage <= '0;
            prm       <= '0;
            rise_mask <= '0;
            fall_mask <= '0;
            fast_mode <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_ROW_LO:  row_stage[7:0]  <= cfg_wdata;
                A_ROW_HI:  row_stage[15:8] <= cfg_wdata;
                A_PRM0: begin
                    prm.gate  <= gate_e'(cfg_wdata[7:6]);
                    prm.presc <= cfg_wdata[5:0];
                end
                A_PRM1: begin
                    prm.src   <= src_e'(cfg_wdata[7:6]);
                    prm.op    <= op_e'(cfg_wdata[5:4]);
                    prm.sel_a <= cfg_wdata[3:2];
                    prm.sel_b <= cfg_wdata[1:0];
                end
                A_CMPB_LO: prm.cmp_b[7:0]  <= cfg_wdata;
                A_CMPB_HI: prm.cmp_b[15:8] <= cfg_wdata;
                A_CMPA_LO: prm.cmp_a[7:0]  <= cfg_wdata;
                A_CMPA_HI: prm.cmp_a[15:8] <= cfg_wdata;
                A_RISE_LO: rise_mask[7:0]  <= cfg_wdata;
                A_RISE_HI: rise_mask[15:8] <= cfg_wdata;
                A_FALL_LO: fall_mask[7:0]  <= cfg_wdata;
                A_FALL_HI: fall_mask[15:8] <= cfg_wdata;
                A_MODE:    fast_mode       <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    qlt_lut_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .row_idx  (cfg_wdata[QW-1:0]),
        .row_bits (row_stage),
        .sample   (smp_data),
        .term_hit (term_hit)
    );

    qlt_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .rearm    (rearm),
        .valid    (smp_valid),
        .prm      (prm),
        .term_hit (term_hit),
        .level_ok (level_ok)
    );

    qlt_edge #(.W(NCH)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .valid     (smp_valid),
        .sample    (smp_data),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .sel_none  (sel_none),
        .sel_one   (sel_one),
        .edge_hit  (edge_hit)
    );

    assign cond = fast_mode ? (sel_one && edge_hit)
                            : (level_ok && (sel_none || (sel_one && edge_hit)));

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            trig_pulse <= 1'b0;
            triggered  <= 1'b0;
        end else begin
            trig_pulse <= smp_valid && cond && !triggered;
            if (smp_valid && cond)
                triggered <= 1'b1;
        end
    end
endmodule

// File: rtl/qlt_trigger_chk.sv
module qlt_trigger_chk (
    input logic        clk,
    input logic        rst,
    input logic        rearm,
    input logic        smp_valid,
    input logic        trig_pulse,
    input logic        triggered,
    input logic        fast,
    input logic [15:0] rise_m,
    input logic [15:0] fall_m
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!trig_pulse && !triggered)); // R1

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse); // R10

    AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> triggered); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (triggered && !rearm) |=> triggered); // R10

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (!triggered && !trig_pulse)); // R10

    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        triggered |=> !trig_pulse); // R10

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !trig_pulse); // R11

    AST_FAST_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        (fast && ($countones(rise_m | fall_m) != 1)) |=> !trig_pulse); // R8
endmodule

bind qlt_trigger qlt_trigger_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rearm      (rearm),
    .smp_valid  (smp_valid),
    .trig_pulse (trig_pulse),
    .triggered  (triggered),
    .fast       (fast_mode),
    .rise_m     (rise_mask),
    .fall_m     (fall_mask)
);

// File: tb/qlt_trigger_bench.sv
module qlt_trigger_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        rearm = 1'b0;
    logic        trig_pulse, triggered;

    int nchk = 0;
    int nerr = 0;
    logic mdl_trig = 1'b0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [15:0] bl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    qlt_trigger u_qlt_trigger (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
        .rearm(rearm), .trig_pulse(trig_pulse), .triggered(triggered)
    );

    // monitor: pops one expectation per cycle after the edge it belongs to
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            nchk++;
            if (trig_pulse !== e[1] || triggered !== e[0]) begin
                nerr++;
                $display("FAIL %s: pulse=%0b trig=%0b expected pulse=%0b trig=%0b",
                         t, trig_pulse, triggered, e[1], e[0]);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic smp(input logic [15:0] d, input logic c, input string t);
        logic p;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        p = c && !mdl_trig;
        mdl_trig = mdl_trig | c;
        exp_q.push_back({p, mdl_trig});
        tag_q.push_back(t);
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic idle(input logic [15:0] d);
        @(negedge clk);
        smp_data = d;
        exp_q.push_back({1'b0, mdl_trig});
        tag_q.push_back("R11 invalid sample ignored");
        @(posedge clk); #1;
    endtask

    task automatic do_rearm();
        @(negedge clk);
        rearm = 1'b1;
        mdl_trig = 1'b0;
        exp_q.push_back(2'b00);
        tag_q.push_back("R10 rearm clears");
        @(posedge clk); #1;
        rearm = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl_trig = 1'b0;
        nchk++;
        if (trig_pulse !== 1'b0 || triggered !== 1'b0) begin
            nerr++;
            $display("FAIL R1 reset: pulse=%0b trig=%0b expected 0 0", trig_pulse, triggered);
        end
    endtask

    task automatic setp(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [15:0] cb, input logic [15:0] ca);
        wr(4'd3, b0); wr(4'd4, b1);
        wr(4'd5, cb[7:0]); wr(4'd6, cb[15:8]);
        wr(4'd7, ca[7:0]); wr(4'd8, ca[15:8]);
    endtask

    task automatic load_rows();
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            for (int k = 0; k < 16; k++) w[k] = bl[k][i];
            wr(4'd0, w[7:0]);
            wr(4'd1, w[15:8]);
            wr(4'd2, 8'h30 | 8'(i));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nerr++;
        $display("FAIL watchdog expired: got hung run expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nchk++;
        if (trig_pulse !== 1'b0 || triggered !== 1'b0) begin
            nerr++;
            $display("FAIL R1 reset: pulse=%0b trig=%0b expected 0 0", trig_pulse, triggered);
        end

        // R1 default tables, R11 invalid cycle, R10 sticky flag
        idle(16'h0005);
        smp(16'h1234, 1'b1, "R1 default tables match");
        smp(16'h0000, 1'b1, "R10 no second pulse");
        do_rearm();

        // R3 table loading: term0 group0 == 5, term1 group1 == A, terms 2,3 never
        for (int k = 0; k < 16; k++) bl[k] = (k >= 8) ? 16'h0000 : 16'hFFFF;
        bl[0] = 16'h0020;
        bl[5] = 16'h0400;
        load_rows();
        smp(16'h1234, 1'b0, "R3 group0 mismatch");
        smp(16'h1235, 1'b1, "R3 group0 match");
        do_rearm();

        // R4 operators
        setp(8'h00, 8'h11, 16'd0, 16'd0);
        smp(16'h0005, 1'b0, "R4 and, B false");
        smp(16'h00A5, 1'b1, "R4 and, both true");
        do_rearm();
        setp(8'h00, 8'h21, 16'd0, 16'd0);
        smp(16'h0000, 1'b0, "R4 or, none");
        smp(16'h00A0, 1'b1, "R4 or, B only");
        do_rearm();
        setp(8'h00, 8'h31, 16'd0, 16'd0);
        smp(16'h00A5, 1'b0, "R4 xor, both");
        smp(16'h00A0, 1'b1, "R4 xor, one");
        do_rearm();
        setp(8'h00, 8'h08, 16'd0, 16'd0);
        smp(16'h00A5, 1'b0, "R4 term A select 2");

        // R6 gate 1: counter of M reaching compare A = 3
        setp(8'h40, 8'h00, 16'd0, 16'd3);
        do_rearm();
        smp(16'h0005, 1'b0, "R6 count 0");
        smp(16'h0000, 1'b0, "R6 count 1 no match");
        smp(16'h0005, 1'b0, "R6 count 1");
        smp(16'h0005, 1'b0, "R6 count 2");
        smp(16'h0000, 1'b1, "R6 count reached");
        do_rearm();

        // R5 prescaler ticks every 2 samples, R6 gate 2 with compare B = 2
        setp(8'h81, 8'hC0, 16'd2, 16'd0);
        do_rearm();
        smp(16'h0005, 1'b0, "R5 tick pre 0");
        smp(16'h0005, 1'b0, "R5 tick pre 1");
        smp(16'h0005, 1'b0, "R5 tick cnt 1");
        smp(16'h0005, 1'b0, "R5 tick cnt 1b");
        smp(16'h0005, 1'b1, "R5 counter at 2 gate open");
        do_rearm();

        // R6 window gate, counting A
        setp(8'hC0, 8'h40, 16'd2, 16'd3);
        do_rearm();
        smp(16'h0005, 1'b0, "R6 window below 0");
        smp(16'h0005, 1'b0, "R6 window below 1");
        smp(16'h0005, 1'b1, "R6 window inside");
        do_rearm();

        // R7 normal-mode edge condition, rising on pin 8
        setp(8'h00, 8'h00, 16'd0, 16'd0);
        wr(4'd10, 8'h01);
        smp(16'h0005, 1'b0, "R7 level without edge");
        smp(16'h0105, 1'b1, "R7 rise with level");
        do_rearm();
        smp(16'h0105, 1'b0, "R7 steady high");
        smp(16'h0004, 1'b0, "R7 fall not selected");
        smp(16'h0104, 1'b0, "R7 rise without level");
        wr(4'd12, 8'h02);
        smp(16'h0005, 1'b0, "R7 two pins set");
        smp(16'h0105, 1'b0, "R7 two pins set rise");
        wr(4'd12, 8'h00);

        // R8 fast mode
        wr(4'd13, 8'h01);
        smp(16'h0000, 1'b0, "R8 fall on rise pin");
        smp(16'h0100, 1'b1, "R8 rise level ignored");
        do_rearm();
        wr(4'd10, 8'h00);
        wr(4'd12, 8'h02);
        smp(16'h0200, 1'b0, "R8 rise on fall pin");
        smp(16'h0000, 1'b1, "R8 fall");
        do_rearm();
        wr(4'd12, 8'h00);
        smp(16'h0005, 1'b0, "R8 no pin set");
        smp(16'h0000, 1'b0, "R8 no pin set b");

        // R9 first sample after reset has no edge
        do_reset();
        wr(4'd13, 8'h01);
        wr(4'd9, 8'h01);
        smp(16'h0001, 1'b0, "R9 first sample");
        smp(16'h0000, 1'b0, "R9 fall only");
        smp(16'h0001, 1'b1, "R9 rise after history");

        // R2 commit key
        do_reset();
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
        wr(4'd2, 8'h25);
        smp(16'h0005, 1'b1, "R2 bad key ignored");
        do_rearm();
        wr(4'd2, 8'h35);
        smp(16'h0005, 1'b0, "R2 row 5 cleared");
        smp(16'h0004, 1'b1, "R2 row 4 untouched");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule